// File: doc/BRIEF.md
# Machine Instruction Step Controller

This block paces every machine instruction of a microcoded 16-bit processor. It asks the bus for the next instruction word and holds that word in its instruction register. It sorts the word into one of four groups: two-operand, one-operand, zero-operand or special. For each operand the instruction needs, it calls a microcode operand-fetch routine. It then forms a 7-bit microcode entry address for the instruction itself, hands that address to the microcode sequencer and waits for the sequencer to report completion. After that it fetches the next word.

Every microcode call has the same shape. A one-cycle start strobe carries the entry address, and the controller holds its step until the sequencer returns a one-cycle done pulse. The operand-fetch routines place the source operand in the left ALU latch and the destination operand in the right ALU latch. The controller only selects which routine runs and in which order.

Top module: `insn_step_ctrl`

## Requirements
- R1: One cycle after reset, `fetch_req` is 1, `mc_start` is 0 and `ir_out` is 0.
- R2: A `fetch_done` pulse seen while `fetch_req` is high loads `instr_word` into `ir_out`, and `fetch_req` is low in the next cycle. A `fetch_done` pulse seen at any other time leaves `ir_out` unchanged.
- R3: A word with bits 15..12 not equal to 1111 is two-operand. Its calls come in this order:
  - source fetch at address {100,0,bits 5..3}, in the cycle right after the fetch completes;
  - destination fetch at {100,0,bits 11..9}, in the cycle right after the source done;
  - instruction entry at {001,bits 15..12}.
- R4: A word 1111 with bits 11..9 = 110 is one-operand. It makes no source call. Its destination call at {100,0,bits 5..3} comes in the cycle right after the fetch, and its instruction entry is {010,bits 9..6}.
- R5: A word 1111 with bits 11..4 = 11111100 is zero-operand. It makes no operand calls, and its only call goes to {011,bits 3..0}.
- R6: The other words with prefix 1111 are special, and their entry address is 000 followed by a 4-bit code:
  - bit 11 = 0 (relative branch): code 0100;
  - bits 11..6 = 100000: code 0000;
  - bits 11..6 = 100001: code 0001;
  - bits 11..6 = 100010: code 0010;
  - bits 11..6 = 100011: code 0011.
- R7: A 1111 word that matches none of the patterns in R4 to R6 is dispatched to special code 1111 (address 0001111).
- R8: `mc_start` is high for exactly one cycle per call. The step holds until `mc_done` arrives, and `mc_done` has no effect while no call is outstanding.
- R9: The entry lookup costs one cycle. The instruction-entry start appears in the second cycle after the edge where the last operand done, or for zero-operand and special words the fetch, was taken.
- R10: The cycle after the instruction-entry done is taken, `fetch_req` is high again.
- R11: No start ever carries prefix 110 or 111. Operand-fetch addresses (bit 6 = 1) always have bit 3 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | output | 1 | Bus read request for the next instruction word |
| fetch_done | input | 1 | Bus reports that `instr_word` is valid |
| instr_word | input | 16 | Instruction word from the bus |
| ir_out | output | 16 | Instruction register contents |
| mc_start | output | 1 | One-cycle strobe that calls the microcode sequencer |
| mc_addr | output | 7 | Microcode entry address, valid with `mc_start` |
| mc_done | input | 1 | Sequencer completion pulse |

## Verification
The package fixes the widths: a 16-bit word, a 7-bit entry address, 3-bit addressing modes and 4-bit low codes. The bench therefore builds the block at these defaults only, and those defaults put every group boundary within reach. That includes the 1110/1111 opcode edge, the 110 and 11111100 escapes, all five special codes and the unmatched 1111 words. Directed words exercise each of these. Call latencies are checked cycle-exactly, so a skipped step, an extra step or a missing lookup cycle shows up as a latency miscompare. Stray `mc_done` and `fetch_done` pulses are injected while nothing is waiting for them.

// File: rtl/isc_pkg.sv
package isc_pkg;

    localparam int WORD_W  = 16;
    localparam int ADDR_W  = 7;
    localparam int MODE_W  = 3;
    localparam int LOW_W   = 4;
    localparam int PFX_W   = ADDR_W - LOW_W;
    localparam int NSTEP   = 5;

    // one-hot step positions
    localparam int ST_FETCH = 0;
    localparam int ST_SRC   = 1;
    localparam int ST_DST   = 2;
    localparam int ST_LOOK  = 3;
    localparam int ST_RUN   = 4;

    typedef enum logic [1:0] {
        GRP_SPECIAL = 2'b00,
        GRP_TWO     = 2'b01,
        GRP_ONE     = 2'b10,
        GRP_ZERO    = 2'b11
    } grp_e;

    localparam logic [PFX_W-1:0] PFX_OPND = 3'b100;
    localparam logic [PFX_W-1:0] PFX_SAVE = 3'b101;

    localparam logic [LOW_W-1:0] SPC_MASK   = 4'b0000;
    localparam logic [LOW_W-1:0] SPC_SWINT  = 4'b0001;
    localparam logic [LOW_W-1:0] SPC_JUMP   = 4'b0010;
    localparam logic [LOW_W-1:0] SPC_CALL   = 4'b0011;
    localparam logic [LOW_W-1:0] SPC_BRANCH = 4'b0100;
    localparam logic [LOW_W-1:0] SPC_BAD    = 4'b1111;

    typedef struct packed {
        grp_e              grp;
        logic [LOW_W-1:0]  low;
        logic [MODE_W-1:0] src_mode;
        logic [MODE_W-1:0] dst_mode;
    } word_class_t;

    function automatic logic [ADDR_W-1:0] opnd_entry(input logic [MODE_W-1:0] mode);
        return {PFX_OPND, {(LOW_W-MODE_W){1'b0}}, mode};
    endfunction

    function automatic logic [ADDR_W-1:0] insn_entry(input grp_e g, input logic [LOW_W-1:0] low);
        return {1'b0, g, low};
    endfunction

endpackage

// File: rtl/isc_group_decode.sv
module isc_group_decode
    import isc_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output word_class_t       cls
);

    logic              is_esc;
    logic              is_one;
    logic              is_zero;
    logic [LOW_W-1:0]  spc_code;
    grp_e              grp;

    always_comb begin
        is_esc  = (word[15:12] == 4'b1111);
        is_one  = is_esc && (word[11:9] == 3'b110);
        is_zero = is_esc && (word[11:4] == 8'b1111_1100);
        if (!is_esc)      grp = GRP_TWO;
        else if (is_one)  grp = GRP_ONE;
        else if (is_zero) grp = GRP_ZERO;
        else              grp = GRP_SPECIAL;
    end

    always_comb begin
        if (!word[11]) begin
            spc_code = SPC_BRANCH;
        end else begin
            case (word[11:6])
                6'b100000: spc_code = SPC_MASK;
                6'b100001: spc_code = SPC_SWINT;
                6'b100010: spc_code = SPC_JUMP;
                6'b100011: spc_code = SPC_CALL;
                default:   spc_code = SPC_BAD;
            endcase
        end
    end

    // group code steers the low-field selection directly
    always_comb begin
        cls.grp      = grp;
        cls.src_mode = word[5:3];
        case (grp)
            GRP_TWO: begin
                cls.low      = word[15:12];
                cls.dst_mode = word[11:9];
            end
            GRP_ONE: begin
                cls.low      = word[9:6];
                cls.dst_mode = word[5:3];
            end
            GRP_ZERO: begin
                cls.low      = word[3:0];
                cls.dst_mode = word[5:3];
            end
            default: begin
                cls.low      = spc_code;
                cls.dst_mode = word[5:3];
            end
        endcase
    end

endmodule

// File: rtl/isc_step_seq.sv
module isc_step_seq
    import isc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch_done,
    input  logic             mc_done,
    input  grp_e             new_grp,
    output logic [NSTEP-1:0] step_q,
    output logic             pending_q,
    output logic             fetch_req,
    output logic             mc_start,
    output logic             load_ir,
    output logic             latch_entry
);

    logic [NSTEP-1:0] step_n;
    logic             call_step;
    logic             call_end;

    always_comb begin
        fetch_req   = step_q[ST_FETCH];
        call_step   = step_q[ST_SRC] | step_q[ST_DST] | step_q[ST_RUN];
        mc_start    = call_step & ~pending_q;
        call_end    = call_step & pending_q & mc_done;
        load_ir     = fetch_req & fetch_done;
        latch_entry = step_q[ST_LOOK];
    end

    always_comb begin
        step_n = step_q;
        if (load_ir) begin
            step_n = '0;
            case (new_grp)
                GRP_TWO: step_n[ST_SRC]  = 1'b1;
                GRP_ONE: step_n[ST_DST]  = 1'b1;
                default: step_n[ST_LOOK] = 1'b1;
            endcase
        end else if (step_q[ST_LOOK]) begin
            step_n = '0;
            step_n[ST_RUN] = 1'b1;
        end else if (call_end) begin
            step_n = '0;
            if (step_q[ST_SRC])      step_n[ST_DST]   = 1'b1;
            else if (step_q[ST_DST]) step_n[ST_LOOK]  = 1'b1;
            else                     step_n[ST_FETCH] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q           <= '0;
            step_q[ST_FETCH] <= 1'b1;
            pending_q        <= 1'b0;
        end else begin
            step_q <= step_n;
            if (mc_start)      pending_q <= 1'b1;
            else if (call_end) pending_q <= 1'b0;
        end
    end

endmodule

// File: rtl/isc_addr_mux.sv
module isc_addr_mux
    import isc_pkg::*;
(
    input  logic [NSTEP-1:0]  step_q,
    input  word_class_t       cls,
    input  logic [ADDR_W-1:0] entry_q,
    output logic [ADDR_W-1:0] mc_addr
);

    always_comb begin
        if (step_q[ST_SRC])      mc_addr = opnd_entry(cls.src_mode);
        else if (step_q[ST_DST]) mc_addr = opnd_entry(cls.dst_mode);
        else if (step_q[ST_RUN]) mc_addr = entry_q;
        else                     mc_addr = '0;
    end

endmodule

// File: rtl/insn_step_ctrl.sv
module insn_step_ctrl
    import isc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic              fetch_req,
    input  logic              fetch_done,
    input  logic [WORD_W-1:0] instr_word,
    output logic [WORD_W-1:0] ir_out,
    output logic              mc_start,
    output logic [ADDR_W-1:0] mc_addr,
    input  logic              mc_done
);

    word_class_t       in_cls;
    word_class_t       ir_cls;
    logic [NSTEP-1:0]  step_q;
    logic              pending_q;
    logic              load_ir;
    logic              latch_entry;
    logic [WORD_W-1:0] ir_q;
    logic [ADDR_W-1:0] entry_q;

    isc_group_decode u_dec_in (.word(instr_word), .cls(in_cls));
    isc_group_decode u_dec_ir (.word(ir_q),       .cls(ir_cls));

    isc_step_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .fetch_done (fetch_done),
        .mc_done    (mc_done),
        .new_grp    (in_cls.grp),
        .step_q     (step_q),
        .pending_q  (pending_q),
        .fetch_req  (fetch_req),
        .mc_start   (mc_start),
        .load_ir    (load_ir),
        .latch_entry(latch_entry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q    <= '0;
            entry_q <= '0;
        end else begin
            if (load_ir)     ir_q    <= instr_word;
            if (latch_entry) entry_q <= insn_entry(ir_cls.grp, ir_cls.low);
        end
    end

    isc_addr_mux u_mux (
        .step_q (step_q),
        .cls    (ir_cls),
        .entry_q(entry_q),
        .mc_addr(mc_addr)
    );

    assign ir_out = ir_q;

endmodule

// File: rtl/isc_checker.sv
module isc_checker
    import isc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fetch_req,
    input logic              fetch_done,
    input logic [WORD_W-1:0] instr_word,
    input logic [WORD_W-1:0] ir_out,
    input logic              mc_start,
    input logic [ADDR_W-1:0] mc_addr,
    input logic              mc_done,
    input logic [NSTEP-1:0]  step_q,
    input logic              pending_q
);

    a_r8_single_step: assert property (@(posedge clk) disable iff (rst)
        $countones(step_q) == 1);

    a_r8_start_pulse: assert property (@(posedge clk) disable iff (rst)
        mc_start |=> !mc_start);

    a_r2_ir_load: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && fetch_done) |=> (ir_out == $past(instr_word)) && !fetch_req);

    a_r2_ir_hold: assert property (@(posedge clk) disable iff (rst)
        !fetch_req |=> $stable(ir_out));

    a_r11_no_bad_prefix: assert property (@(posedge clk) disable iff (rst)
        mc_start |-> (mc_addr[6:5] != 2'b11));

    a_r11_opnd_bit3: assert property (@(posedge clk) disable iff (rst)
        (mc_start && mc_addr[6]) |-> !mc_addr[3]);

    a_r10_refetch: assert property (@(posedge clk) disable iff (rst)
        (step_q[ST_RUN] && pending_q && mc_done) |=> fetch_req);

    a_r8_no_start_in_fetch: assert property (@(posedge clk) disable iff (rst)
        fetch_req |-> !mc_start);

endmodule

bind insn_step_ctrl isc_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .fetch_req (fetch_req),
    .fetch_done(fetch_done),
    .instr_word(instr_word),
    .ir_out    (ir_out),
    .mc_start  (mc_start),
    .mc_addr   (mc_addr),
    .mc_done   (mc_done),
    .step_q    (step_q),
    .pending_q (pending_q)
);

// File: tb/insn_step_ctrl_tb_top.sv
module insn_step_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_req;
    logic        fetch_done = 1'b0;
    logic [15:0] instr_word = '0;
    logic [15:0] ir_out;
    logic        mc_start;
    logic [6:0]  mc_addr;
    logic        mc_done = 1'b0;

    int n_vec  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    insn_step_ctrl dut_i (
        .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_done(fetch_done),
        .instr_word(instr_word), .ir_out(ir_out), .mc_start(mc_start),
        .mc_addr(mc_addr), .mc_done(mc_done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // completes a fetch; returns at the negedge of the cycle after the load edge
    task automatic do_fetch(input logic [15:0] w, input string tag);
        int guard = 0;
        while (!fetch_req && guard < 20) begin
            @(negedge clk);
            guard++;
        end
        chk({tag, " R2 fetch_req before load"}, fetch_req, 1);
        instr_word = w;
        fetch_done = 1'b1;
        @(negedge clk);
        fetch_done = 1'b0;
        chk({tag, " R2 ir loaded"}, ir_out, w);
        chk({tag, " R2 fetch_req dropped"}, fetch_req, 0);
    endtask

    // waits for a call, checks latency and address, then answers with done
    task automatic expect_call(input int lat, input logic [6:0] a,
                               input int hold, input string tag);
        int waited = 0;
        while (!mc_start && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        chk({tag, " latency"}, waited, lat);
        chk({tag, " start seen"}, mc_start, 1);
        chk({tag, " addr"}, mc_addr, a);
        for (int i = 0; i <= hold; i++) begin
            @(negedge clk);
            chk({tag, " R8 start is one cycle"}, mc_start, 0);
        end
        mc_done = 1'b1;
        @(negedge clk);
        mc_done = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 fetch_req", fetch_req, 1);
        chk("R1 mc_start", mc_start, 0);
        chk("R1 ir", ir_out, 0);
    endtask

    task automatic t_two_op;
        do_fetch(16'h56B1, "two");
        expect_call(0, 7'h46, 0, "R3 src");
        expect_call(0, 7'h43, 2, "R3 dst");
        expect_call(1, 7'h15, 0, "R3 R9 entry");
        chk("R10 refetch", fetch_req, 1);
        do_fetch(16'hE000, "two-edge");
        expect_call(0, 7'h40, 0, "R3 src edge");
        expect_call(0, 7'h40, 0, "R3 dst edge");
        expect_call(1, 7'h1E, 0, "R3 entry edge");
        chk("R10 refetch edge", fetch_req, 1);
    endtask

    task automatic t_one_op;
        do_fetch(16'hFCEA, "one");
        expect_call(0, 7'h45, 0, "R4 dst");
        expect_call(1, 7'h23, 0, "R4 R9 entry");
        chk("R10 refetch one", fetch_req, 1);
    endtask

    task automatic t_zero_op;
        do_fetch(16'hFFC9, "zero");
        expect_call(1, 7'h39, 0, "R5 R9 entry");
        chk("R10 refetch zero", fetch_req, 1);
    endtask

    task automatic t_special;
        do_fetch(16'hF5A3, "bra");
        expect_call(1, 7'h04, 0, "R6 branch");
        do_fetch(16'hF82A, "msk");
        expect_call(1, 7'h00, 0, "R6 mask");
        do_fetch(16'hF855, "swi");
        expect_call(1, 7'h01, 0, "R6 swint");
        do_fetch(16'hF885, "jmp");
        expect_call(1, 7'h02, 0, "R6 jump");
        do_fetch(16'hF8C3, "jsr");
        expect_call(1, 7'h03, 0, "R6 call");
    endtask

    task automatic t_unknown;
        do_fetch(16'hF900, "unk1");
        expect_call(1, 7'h0F, 0, "R7 unmatched 1001");
        do_fetch(16'hFE00, "unk2");
        expect_call(1, 7'h0F, 0, "R7 unmatched 111");
    endtask

    task automatic t_ignore;
        // stray done while fetching
        mc_done = 1'b1;
        @(negedge clk);
        mc_done = 1'b0;
        chk("R8 stray done keeps fetch", fetch_req, 1);
        chk("R8 stray done no start", mc_start, 0);
        do_fetch(16'h2A5B, "ign");
        // src call pending; a stray fetch_done must not reload the IR
        chk("R3 src addr ign", mc_addr, 7'h43);
        @(negedge clk);
        instr_word = 16'hFFFF;
        fetch_done = 1'b1;
        @(negedge clk);
        fetch_done = 1'b0;
        chk("R2 stray fetch_done ignored", ir_out, 16'h2A5B);
        mc_done = 1'b1;
        @(negedge clk);
        mc_done = 1'b0;
        expect_call(0, 7'h45, 4, "R2 dst after stray");
        expect_call(1, 7'h12, 0, "R3 entry after stray");
        chk("R10 refetch ign", fetch_req, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!ended) begin
            n_fail++;
            n_vec++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_two_op();
        t_one_op();
        t_zero_op();
        t_special();
        t_unknown();
        t_ignore();
        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule